// File: doc/BRIEF.md
# ISA Slave Ready Responder

This block sits on the bridge side of an ISA bus. It answers an external bus master that reads or writes a resource the bridge owns, such as main memory or a bridge register. It watches the incoming read and write command strobes and the address. When a command falls inside a configured address window, the block pulls the channel-ready line low to insert wait states. It then asks an internal data path to supply read data, or tells that path that write data has been latched, and waits for a data-ready acknowledge.

Once the acknowledge arrives, the block drives ready high for a fixed interval. The interval is given in nanoseconds and converted to clock cycles, rounding up. After that interval the block stops driving the line and leaves it to the bus pull-up. The ready line leaves the block as a value and a separate output enable, so the pad can tri-state it. On reads, the block also keeps the read-data enable asserted until the read strobe has been seen high again.

The command strobes arrive from the bus without any relation to the clock. Each one passes through a two-flop synchroniser, and a falling edge is detected on the synchronised copy. Access to the internal memory itself, bus arbitration and the bridge's own master cycles are handled elsewhere.

Top module: `isa_rdy_resp`

## Requirements
- R1: A command is claimed on the falling edge of ior_ni (read) or iow_ni (write), both active low. The claim needs ext_own_i high and addr_i in the window BASE..LIMIT inclusive. Three rising clock edges after the strobe is seen low, rdy_oe_o is 1 and rdy_o is 0.
- R2: A data_ack_i seen while ready is held low makes rdy_o = 1 with rdy_oe_o = 1 for exactly HOLD_CYC = ceil(HOLD_NS / CLK_NS) cycles. After those cycles rdy_oe_o returns to 0.
- R3: A command is ignored, with rdy_oe_o, rd_req_o and wr_lat_o all staying 0, if its address is outside the window or ext_own_i is low.
- R4: While cpu_rst_i is 1, rdy_oe_o is 0 in the same cycle. The block then returns to idle.
- R5: While a read is held low, rd_req_o is 1. While a write is held low, wr_lat_o is 1. The two are never 1 together, and neither is 1 unless ready is being driven low.
- R6: On a claimed read, rd_data_oe_o rises together with the high ready drive. It falls on the third rising edge after ior_ni returns high, so it stays asserted past the deassertion of the strobe.
- R7: If the claimed strobe returns high before data_ack_i arrives, the handshake is aborted. rdy_oe_o drops three edges after the strobe rises, and no high drive follows.
- R8: After reset, with both strobes high, rdy_oe_o, rd_req_o, wr_lat_o and rd_data_oe_o are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bridge clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cpu_rst_i | input | 1 | Processor reset; forces ready to high impedance |
| ext_own_i | input | 1 | External master owns the bus |
| ior_ni | input | 1 | Read command strobe, active low |
| iow_ni | input | 1 | Write command strobe, active low |
| addr_i | input | AW | Address from the external master |
| data_ack_i | input | 1 | Internal data path: data ready / write taken |
| rd_req_o | output | 1 | Read request to the data path |
| wr_lat_o | output | 1 | Write data latched, to the data path |
| rd_data_oe_o | output | 1 | Enable for driving read data onto the bus |
| rdy_o | output | 1 | Ready line value |
| rdy_oe_o | output | 1 | Ready line output enable |

## Verification
The assertions check the following rules on every clock cycle:
- ready is never driven while processor reset is active;
- the read request and the write-latched flag are never active together, and neither is active outside the low-drive phase;
- an acknowledge always produces the high drive on the next cycle;
- the high drive never lasts longer than the computed interval;
- every claim traces back to an owned, in-window address.

Some behaviour can only be seen in the bench scenarios. These are:
- the exact three-edge latency through the synchroniser;
- the full length of the high drive followed by release;
- the delayed read-data release after the strobe rises;
- aborts;
- the decode sweep over every address and command type, with and without bus ownership.

// File: rtl/isa_rdy_pkg.sv
package isa_rdy_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WAIT,
    ST_HOLD
  } rdy_state_e;
endpackage

// File: rtl/isa_cmd_sync.sv
module isa_cmd_sync #(
  parameter int N = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] strb_ni,
  output logic [N-1:0] act_o,
  output logic [N-1:0] fall_o
);
  for (genvar g = 0; g < N; g++) begin : g_strb
    logic [2:0] sh_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sh_q <= 3'b111;
      else         sh_q <= {sh_q[1:0], strb_ni[g]};
    end
    // sh_q[1] is the synchronised strobe, sh_q[2] its previous value
    assign act_o[g]  = ~sh_q[1];
    assign fall_o[g] = sh_q[2] & ~sh_q[1];
  end
endmodule

// File: rtl/isa_win_decode.sv
module isa_win_decode #(
  parameter int            AW    = 24,
  parameter logic [AW-1:0] BASE  = '0,
  parameter logic [AW-1:0] LIMIT = '1
) (
  input  logic [AW-1:0] addr_i,
  input  logic          own_i,
  output logic          hit_o
);
  logic lo_ok, hi_ok;
  if (BASE == '0) begin : g_no_lo
    assign lo_ok = 1'b1;
  end else begin : g_lo
    assign lo_ok = (addr_i >= BASE);
  end
  if (LIMIT == '1) begin : g_no_hi
    assign hi_ok = 1'b1;
  end else begin : g_hi
    assign hi_ok = (addr_i <= LIMIT);
  end
  assign hit_o = own_i & lo_ok & hi_ok;
endmodule

// File: rtl/isa_rdy_fsm.sv
module isa_rdy_fsm
  import isa_rdy_pkg::*;
#(
  parameter int HOLD_CYC = 7
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cpu_rst_i,
  input  logic start_rd_i,
  input  logic start_wr_i,
  input  logic rd_act_i,
  input  logic wr_act_i,
  input  logic data_ack_i,
  output logic rdy_o,
  output logic rdy_oe_o,
  output logic rd_req_o,
  output logic wr_lat_o,
  output logic rd_drv_o
);
  localparam int CW = (HOLD_CYC > 1) ? $clog2(HOLD_CYC) : 1;

  rdy_state_e state_q;
  logic [CW-1:0] cnt_q;
  logic is_rd_q, rd_drv_q, cmd_act;

  assign cmd_act = is_rd_q ? rd_act_i : wr_act_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      cnt_q    <= '0;
      is_rd_q  <= 1'b0;
      rd_drv_q <= 1'b0;
    end else if (cpu_rst_i) begin
      state_q  <= ST_IDLE;
      cnt_q    <= '0;
      rd_drv_q <= 1'b0;
    end else begin
      if (rd_drv_q && !rd_act_i) rd_drv_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start_rd_i) begin
            state_q <= ST_WAIT;
            is_rd_q <= 1'b1;
          end else if (start_wr_i) begin
            state_q <= ST_WAIT;
            is_rd_q <= 1'b0;
          end
        end
        ST_WAIT: begin
          if (data_ack_i) begin
            state_q <= ST_HOLD;
            cnt_q   <= CW'(HOLD_CYC - 1);
            if (is_rd_q) rd_drv_q <= 1'b1;
          end else if (!cmd_act) begin
            state_q <= ST_IDLE; // strobe gone before data: abort
          end
        end
        ST_HOLD: begin
          if (cnt_q == '0) state_q <= ST_IDLE;
          else             cnt_q   <= cnt_q - 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign rdy_oe_o = (state_q != ST_IDLE) && !cpu_rst_i;
  assign rdy_o    = (state_q == ST_HOLD);
  assign rd_req_o = (state_q == ST_WAIT) &&  is_rd_q && !cpu_rst_i;
  assign wr_lat_o = (state_q == ST_WAIT) && !is_rd_q && !cpu_rst_i;
  assign rd_drv_o = rd_drv_q;

  // high-drive run length, checker only
  int unsigned hi_run_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  hi_run_q <= 0;
    else if (rdy_o && rdy_oe_o)   hi_run_q <= hi_run_q + 1;
    else                          hi_run_q <= 0;
  end

  a_r5_req_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_req_o && wr_lat_o));
  a_r5_req_in_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_req_o || wr_lat_o) |-> (rdy_oe_o && !rdy_o));
  a_r2_ack_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rdy_oe_o && !rdy_o && data_ack_i && !cpu_rst_i) |=> (rdy_o && (cpu_rst_i || rdy_oe_o)));
  a_r2_hold_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hi_run_q <= HOLD_CYC);
  a_r7_abort: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WAIT && !cmd_act && !data_ack_i && !cpu_rst_i) |=> !rdy_oe_o);
  a_r6_rd_drv_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rd_drv_o) |-> rdy_o);
endmodule

// File: rtl/isa_rdy_resp.sv
module isa_rdy_resp #(
  parameter int            AW      = 24,
  parameter logic [AW-1:0] BASE    = AW'(24'h10_0000),
  parameter logic [AW-1:0] LIMIT   = AW'(24'h1F_FFFF),
  parameter int            CLK_NS  = 10,
  parameter int            HOLD_NS = 70
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cpu_rst_i,
  input  logic          ext_own_i,
  input  logic          ior_ni,
  input  logic          iow_ni,
  input  logic [AW-1:0] addr_i,
  input  logic          data_ack_i,
  output logic          rd_req_o,
  output logic          wr_lat_o,
  output logic          rd_data_oe_o,
  output logic          rdy_o,
  output logic          rdy_oe_o
);
  localparam int HOLD_CYC = (HOLD_NS + CLK_NS - 1) / CLK_NS;

  logic [1:0] act, fall;
  logic hit, start_rd, start_wr;

  isa_cmd_sync #(.N(2)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .strb_ni ({iow_ni, ior_ni}),
    .act_o   (act),
    .fall_o  (fall)
  );

  isa_win_decode #(.AW(AW), .BASE(BASE), .LIMIT(LIMIT)) u_dec (
    .addr_i (addr_i),
    .own_i  (ext_own_i),
    .hit_o  (hit)
  );

  assign start_rd = fall[0] & hit & ~cpu_rst_i;
  assign start_wr = fall[1] & hit & ~cpu_rst_i;

  isa_rdy_fsm #(.HOLD_CYC(HOLD_CYC)) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cpu_rst_i  (cpu_rst_i),
    .start_rd_i (start_rd),
    .start_wr_i (start_wr),
    .rd_act_i   (act[0]),
    .wr_act_i   (act[1]),
    .data_ack_i (data_ack_i),
    .rdy_o      (rdy_o),
    .rdy_oe_o   (rdy_oe_o),
    .rd_req_o   (rd_req_o),
    .wr_lat_o   (wr_lat_o),
    .rd_drv_o   (rd_data_oe_o)
  );

  a_r4_rst_hiz: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_rst_i |-> !rdy_oe_o);
  a_r3_claim_src: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rdy_oe_o) |-> ($past(ext_own_i) && $past(addr_i) >= BASE && $past(addr_i) <= LIMIT));
endmodule

// File: tb/isa_rdy_resp_tb.sv
module isa_rdy_resp_tb;
  localparam int CLK_NS  = 10;
  localparam int HOLD_NS = 65;
  localparam int AW      = 6;
  localparam int LO      = 16;
  localparam int HI      = 40;
  localparam int HOLD    = (HOLD_NS + CLK_NS - 1) / CLK_NS;

  logic clk = 0, rst_n = 0, cpu_rst = 0, own = 0, ior_n = 1, iow_n = 1, ack = 0;
  logic [AW-1:0] addr = '0;
  logic rd_req, wr_lat, rd_oe, rdy, rdy_oe;
  int n_chk = 0, n_fail = 0, cyc = 0;

  always #(CLK_NS/2) clk = ~clk;

  isa_rdy_resp #(.AW(AW), .BASE(AW'(LO)), .LIMIT(AW'(HI)), .CLK_NS(CLK_NS), .HOLD_NS(HOLD_NS)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cpu_rst_i(cpu_rst), .ext_own_i(own),
    .ior_ni(ior_n), .iow_ni(iow_n), .addr_i(addr), .data_ack_i(ack),
    .rd_req_o(rd_req), .wr_lat_o(wr_lat), .rd_data_oe_o(rd_oe),
    .rdy_o(rdy), .rdy_oe_o(rdy_oe)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
      finish_run();
    end
  end

  // full access: rd=1 read, rd=0 write; ack=1 completes, ack=0 aborts
  task automatic access(input bit rd, input int a, input bit o, input bit do_ack);
    bit hit;
    hit = o && a >= LO && a <= HI;
    addr = AW'(a); own = o;
    if (rd) ior_n = 0; else iow_n = 0;
    repeat (3) tick();
    if (hit) begin
      chk("R1 oe", rdy_oe, 1);
      chk("R1 low", rdy, 0);
      chk("R5 rd_req", rd_req, rd ? 1 : 0);
      chk("R5 wr_lat", wr_lat, rd ? 0 : 1);
      if (do_ack) begin
        ack = 1; tick(); ack = 0;
        for (int i = 0; i < HOLD; i++) begin
          chk("R2 high", rdy && rdy_oe, 1);
          if (rd) chk("R6 rd_oe on", rd_oe, 1);
          if (i < HOLD - 1) tick();
        end
        tick();
        chk("R2 release", rdy_oe, 0);
        if (rd) begin
          ior_n = 1; tick(); tick();
          chk("R6 held past strobe", rd_oe, 1);
          tick();
          chk("R6 rd_oe off", rd_oe, 0);
        end else begin
          iow_n = 1; repeat (3) tick();
        end
      end else begin
        if (rd) ior_n = 1; else iow_n = 1;
        tick(); tick();
        chk("R7 still low", rdy_oe, 1);
        tick();
        chk("R7 abort release", rdy_oe, 0);
        repeat (HOLD) begin tick(); chk("R7 no high", rdy_oe, 0); end
      end
    end else begin
      chk("R3 oe", rdy_oe, 0);
      chk("R3 req", rd_req | wr_lat, 0);
      tick(); tick();
      chk("R3 oe later", rdy_oe, 0);
      if (rd) ior_n = 1; else iow_n = 1;
      repeat (3) tick();
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    tick();
    chk("R8 oe", rdy_oe, 0);
    chk("R8 req", rd_req | wr_lat, 0);
    chk("R8 rd_oe", rd_oe, 0);

    for (int a = 0; a < (1 << AW); a++) begin
      access(1'b1, a, 1'b1, 1'b1);
      access(1'b0, a, 1'b1, 1'b1);
    end
    for (int a = LO - 1; a <= HI + 1; a++) access(a[0], a, 1'b0, 1'b1);

    access(1'b1, LO, 1'b1, 1'b0);
    access(1'b0, HI, 1'b1, 1'b0);

    // R4: processor reset during low drive
    addr = AW'(LO + 2); own = 1; ior_n = 0;
    repeat (3) tick();
    chk("R4 pre", rdy_oe, 1);
    cpu_rst = 1; #1;
    chk("R4 hiz same cycle", rdy_oe, 0);
    tick();
    cpu_rst = 0; tick();
    chk("R4 idle after", rdy_oe, 0);
    chk("R4 no req", rd_req, 0);
    ior_n = 1; repeat (3) tick();

    // R4: processor reset during high drive
    addr = AW'(HI); iow_n = 0;
    repeat (3) tick();
    ack = 1; tick(); ack = 0;
    chk("R4 hold pre", rdy_oe, 1);
    cpu_rst = 1; #1;
    chk("R4 hold hiz", rdy_oe, 0);
    tick(); cpu_rst = 0; tick();
    chk("R4 hold idle", rdy_oe, 0);
    iow_n = 1; repeat (3) tick();

    finish_run();
  end
endmodule